// File: doc/BRIEF.md
# Dual Addressable Latch with Clear

This block holds two banks of four storage bits. Both banks share one 2-bit address, an active-low enable and an active-low clear. Each bank has its own single-bit data input. The two control pins pick one of four modes. Clear empties both banks. Memory holds every bit. Addressable latch writes only the addressed bit of each bank. Demultiplex passes data to the addressed bit of each bank and forces the other bits low. Used as an addressable latch, the block loads a serial bit stream into parallel outputs one address at a time.

The design is fully synchronous. The controls, the address and the data are sampled on the rising edge of the system clock, and the outputs come straight from registers. A write therefore becomes visible one clock after it is presented. There is no transparent path from data to output, so a change of several address bits at once cannot reach a wrong location in the middle of a cycle. The interface carries no flow control: the controls and data are plain level inputs and are taken on every clock edge.

Top module: `dual_addr_latch`

## Requirements
- R1: While `rst` is high at a rising edge, all eight outputs are zero after that edge, whatever the level of `clr_n`.
- R2: With `en_n`=1 and `clr_n`=0 (clear), all bits of both `qa` and `qb` become 0 at the next edge.
- R3: With `en_n`=1 and `clr_n`=1 (memory), every output keeps its value. A change of address or data in this mode alters no stored bit, and a value written earlier is still held after enable returns high.
- R4: With `en_n`=0 and `clr_n`=1 (addressable latch), the addressed bit of each bank takes that bank's data input at the next edge, and the other three bits of the bank keep their values.
- R5: With `en_n`=0 and `clr_n`=0 (demultiplex), the addressed bit of each bank takes that bank's data input, and the other three bits of the bank become 0.
- R6: The address is read as an unsigned number with `addr[0]` as the least significant bit. Value 0 selects output bit 0, 1 selects bit 1, 2 selects bit 2 and 3 selects bit 3.
- R7: Both banks use the same mode and the same address. `qa` is written only from `da`, and `qb` only from `db`.
- R8: Outputs change only on a rising clock edge. An input change made between edges is not seen at the outputs until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Bit select shared by both banks |
| en_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Conditional clear, active low |
| da | input | 1 | Data input of bank A |
| db | input | 1 | Data input of bank B |
| qa | output | 4 | Stored bits of bank A |
| qb | output | 4 | Stored bits of bank B |

## Verification
The outputs are the stored state, so a corrupted bit shows at a port on the edge after the wrong update. The bench catches it at the next comparison, one cycle later at most. A bit that is wrongly held or wrongly cleared may match its expected value by chance for a while. For that reason, long runs of random data with mixed modes and mid-sequence mode changes are compared against a behavioural model on every clock, so that such a bit is caught as soon as the model's value differs from it.

// File: rtl/dual_addr_latch_pkg.sv
package dual_addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_DEMUX = 2'd3
  } bank_mode_e;
endpackage

// File: rtl/dal_mode_decode.sv
module dal_mode_decode
  import dual_addr_latch_pkg::*;
(
  input  logic       en_n,
  input  logic       clr_n,
  output bank_mode_e mode
);
  always_comb begin
    unique case ({en_n, clr_n})
      2'b10:   mode = MODE_CLEAR;
      2'b11:   mode = MODE_HOLD;
      2'b01:   mode = MODE_LATCH;
      default: mode = MODE_DEMUX;
    endcase
  end
endmodule

// File: rtl/dal_addr_decode.sv
module dal_addr_decode #(
  parameter int ADDR_W = 2,
  localparam int LANES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  sel
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sel[i] = (addr == ADDR_W'(i));
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1) else $error("select not one-hot"); // R6
endmodule

// File: rtl/dal_bank.sv
module dal_bank
  import dual_addr_latch_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  bank_mode_e       mode,
  input  logic [LANES-1:0] sel,
  input  logic             din,
  output logic [LANES-1:0] q
);
  logic [LANES-1:0] din_rep;
  assign din_rep = {LANES{din}};

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (mode)
        MODE_CLEAR: q <= '0;
        MODE_HOLD:  q <= q;
        MODE_LATCH: q <= (q & ~sel) | (sel & din_rep);
        MODE_DEMUX: q <= sel & din_rep;
        default:    q <= q;
      endcase
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (q == '0)) else $error("reset did not zero bank"); // R1
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CLEAR) |=> (q == '0)) else $error("clear left bits set"); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD) |=> $stable(q)) else $error("memory mode changed bits"); // R3
  AST_UNSEL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH) |=> (((q ^ $past(q)) & ~$past(sel)) == '0))
    else $error("unaddressed bit changed"); // R4
  AST_SEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH || mode == MODE_DEMUX) |=> ((|(q & $past(sel))) == $past(din)))
    else $error("addressed bit missed data"); // R4
  AST_DEMUX_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DEMUX) |=> $onehot0(q)) else $error("demux drove extra bits"); // R5
endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
  import dual_addr_latch_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int LANES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic              da,
  input  logic              db,
  output logic [LANES-1:0]  qa,
  output logic [LANES-1:0]  qb
);
  localparam int NBANK = 2;

  bank_mode_e       mode;
  logic [LANES-1:0] sel;
  logic [NBANK-1:0] din;
  logic [LANES-1:0] q_bus [NBANK];

  assign din = {db, da};

  dal_mode_decode u_mode (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  dal_addr_decode #(.ADDR_W(ADDR_W)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .addr (addr),
    .sel  (sel)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dal_bank #(.LANES(LANES)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .sel  (sel),
      .din  (din[b]),
      .q    (q_bus[b])
    );
  end

  assign qa = q_bus[0];
  assign qb = q_bus[1];

  AST_BANKS_SHARE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr_n) |=> ($countones(qa) <= 1 && $countones(qb) <= 1))
    else $error("bank outputs disagree with shared mode"); // R7
endmodule

// File: tb/dual_addr_latch_tb_top.sv
module dual_addr_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] addr;
  logic       en_n, clr_n, da, db;
  logic [3:0] qa, qb;

  int n_cmp = 0;
  int n_bad = 0;
  bit running = 0;
  bit done = 0;

  int    m_a, m_b;
  string tag;

  always #10 clk = ~clk;

  dual_addr_latch dut_i (
    .clk(clk), .rst(rst), .addr(addr), .en_n(en_n), .clr_n(clr_n),
    .da(da), .db(db), .qa(qa), .qb(qb)
  );

  // Behavioural reference: integers, one bit per address position.
  always @(posedge clk) begin
    int pos;
    pos = 1 << addr;
    if (rst) begin
      m_a = 0; m_b = 0; tag = "R1";
    end else if (en_n && !clr_n) begin
      m_a = 0; m_b = 0; tag = "R2";
    end else if (en_n && clr_n) begin
      tag = "R3";
    end else if (!en_n && clr_n) begin
      m_a = da ? (m_a | pos) : (m_a & ~pos);
      m_b = db ? (m_b | pos) : (m_b & ~pos);
      tag = "R4";
    end else begin
      m_a = da ? pos : 0;
      m_b = db ? pos : 0;
      tag = "R5";
    end
  end

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check({tag, " qa"}, int'(qa), m_a);
      check({tag, " qb"}, int'(qb), m_b);
    end
  end

  task automatic drive(int a, bit e, bit c, bit xa, bit xb);
    @(negedge clk);
    addr = 2'(a); en_n = e; clr_n = c; da = xa; db = xb;
  endtask

  initial begin
    rst = 1; addr = 0; en_n = 1; clr_n = 1; da = 1; db = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset qa", int'(qa), 0);
    check("R1 reset qb", int'(qb), 0);
    running = 1;
    drive(0, 1, 1, 0, 0); rst = 0;
    // R6: walk one bit through each address in latch mode
    for (int i = 0; i < 4; i++) begin
      drive(0, 1, 0, 0, 0);
      drive(i, 0, 1, 1, 0);
      drive(i, 1, 1, 0, 0);
      @(negedge clk);
      check("R6 decode qa", int'(qa), 1 << i);
      check("R7 bank independence qb", int'(qb), 0);
    end
    // R4: fill pattern then keep while address changes in memory mode (R3)
    for (int i = 0; i < 4; i++) drive(i, 0, 1, i[0], ~i[0]);
    for (int i = 0; i < 8; i++) drive(i % 4, 1, 1, i[1], i[0]);
    @(negedge clk);
    check("R3 retained qa", int'(qa), 4'b1010);
    check("R3 retained qb", int'(qb), 4'b0101);
    // R8: change between edges is not seen before next edge
    drive(0, 0, 1, 0, 0);
    #5;
    check("R8 no early change qa", int'(qa), 4'b1010);
    check("R8 no early change qb", int'(qb), 4'b0101);
    // R5: demux sweep, R2 clear
    for (int i = 0; i < 4; i++) drive(i, 0, 0, 1, i[0]);
    drive(1, 1, 0, 1, 1);
    // random mixed modes with mid-sequence changes
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 3), 1'($urandom), 1'($urandom | $urandom),
            1'($urandom), 1'($urandom));
    // reset overrides clr_n high (R1)
    rst = 1;
    drive(2, 0, 1, 1, 1);
    drive(2, 1, 1, 1, 1);
    rst = 0;
    repeat (2) @(negedge clk);
    running = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule